// File: doc/BRIEF.md
# One-Hot IO Register Decoder

This block turns processor load and store cycles that land in the memory-mapped IO window into per-register write and read strobes. The IO window occupies the top of the address space, so software reaches it with a small negative offset from the zero register. Each register owns one bit of the word-offset field instead of an encoded index. A decode is therefore one AND gate per register, and no equality comparator sits on the address.

Because selection is per bit, one store whose offset has several bits set writes the same data into every selected register in the same cycle. A load with several bits set returns the bitwise OR of the selected registers. The block holds a small bank of sample registers to show this: slot 0 is a narrow LED register and the remaining slots are full-width scratch registers.

Top module: `io_onehot_dec`

## Requirements
- R1: An access hits the IO window only when `io_en_i` is high and address bits [31:10] are all ones. For example, 0xFFFF_FE00 hits and selects only register 7.
- R2: `wr_stb_o[i]` is high in the same cycle exactly when the access hits, `we_i` is high and address bit [2+i] is set.
- R3: On the clock edge that ends a cycle with `wr_stb_o[i]` high, register i takes `wdata_i`. When several strobes are high, every selected register loads the same word on that edge.
- R4: `rd_data_o` is the bitwise OR of the contents of every register whose `rd_stb_o` bit is high. It is zero when no read strobe is high.
- R5: `rd_stb_o[i]` is high in the same cycle exactly when the access hits, `re_i` is high and address bit [2+i] is set.
- R6: An access that misses the window raises no strobe, leaves every register unchanged and returns zero read data. A miss is either `io_en_i` low or any of address bits [31:10] clear.
- R7: While `rst_ni` is low, every register is zero.
- R8: Register 0 stores only the low 8 bits of the written word. It reads back zero-extended, and `led_o` mirrors it.
- R9: Address bits [1:0] have no effect on any strobe or read result.
- R10: The highest register sits at byte offset 0x200 below the top of the window. Every register is therefore reachable within a 1024-byte offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Byte address of the access |
| wdata_i | input | 32 | Store data |
| we_i | input | 1 | Store strobe |
| re_i | input | 1 | Load strobe |
| io_en_i | input | 1 | IO space select |
| wr_stb_o | output | 8 | Per-register write strobes |
| rd_stb_o | output | 8 | Per-register read strobes |
| rd_data_o | output | 32 | OR-combined read data |
| led_o | output | 8 | LED register contents |
| regs_o | output | 256 | All register contents, register i at bits [32i+31:32i] |

## Verification
The bench sweeps all 256 values of the one-hot field. Each value is written with a distinct data word and then read back, with the low byte-lane bits varied along the way. Single-bit masks show that each line reaches only its own register. Multi-bit masks show that stores broadcast and that loads OR-merge, and the all-zero mask shows that a load with no select returns zero. A second pass uses full masks but clears each upper address bit in turn or drops the IO select. It confirms that such misses raise no strobe and leave the bank untouched. This separates a true window match from a partial one.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  typedef struct packed {
    logic hit;
    logic wr;
    logic rd;
  } io_acc_t;

  function automatic logic all_set(input logic [63:0] v, input int w);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 64; i++) if (i < w) r &= v[i];
    return r;
  endfunction
endpackage

// File: rtl/io_region_match.sv
module io_region_match #(
  parameter int ADDR_W = 32,
  parameter int HI_LSB = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_en_i,
  output logic              hit_o
);
  localparam int HI_W = ADDR_W - HI_LSB;
  logic [63:0] hi_bits;

  always_comb begin
    hi_bits = '0;
    hi_bits[HI_W-1:0] = addr_i[ADDR_W-1:HI_LSB];
    hit_o = io_en_i & io_dec_pkg::all_set(hi_bits, HI_W);
  end
endmodule

// File: rtl/io_strobe_gen.sv
module io_strobe_gen #(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int SEL_LSB  = 2
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  io_dec_pkg::io_acc_t acc_i,
  output logic [NUM_REGS-1:0] wr_stb_o,
  output logic [NUM_REGS-1:0] rd_stb_o
);
  // one address line per register, one gate per strobe
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_line
    assign wr_stb_o[i] = acc_i.hit & acc_i.wr & addr_i[SEL_LSB+i];
    assign rd_stb_o[i] = acc_i.hit & acc_i.rd & addr_i[SEL_LSB+i];
  end
endmodule

// File: rtl/io_reg_slot.sv
module io_reg_slot #(
  parameter int DATA_W = 32,
  parameter int KEEP_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [KEEP_W-1:0] q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_r <= '0;
    else if (wr_en_i) q_r <= wdata_i[KEEP_W-1:0];
  end

  if (KEEP_W < DATA_W) begin : g_narrow
    assign q_o = {{(DATA_W-KEEP_W){1'b0}}, q_r};
  end else begin : g_full
    assign q_o = q_r;
  end
endmodule

// File: rtl/io_read_or.sv
module io_read_or #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32
) (
  input  logic [NUM_REGS-1:0]        sel_i,
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]          rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      rd_data_o |= regs_i[i*DATA_W +: DATA_W] & {DATA_W{sel_i[i]}};
  end
endmodule

// File: rtl/io_onehot_dec.sv
module io_onehot_dec #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int SEL_LSB  = 2,
  parameter int LED_W    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       we_i,
  input  logic                       re_i,
  input  logic                       io_en_i,
  output logic [NUM_REGS-1:0]        wr_stb_o,
  output logic [NUM_REGS-1:0]        rd_stb_o,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [LED_W-1:0]           led_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int HI_LSB = SEL_LSB + NUM_REGS;

  io_dec_pkg::io_acc_t acc;
  logic hit;

  io_region_match #(.ADDR_W(ADDR_W), .HI_LSB(HI_LSB)) u_match (
    .addr_i (addr_i),
    .io_en_i(io_en_i),
    .hit_o  (hit)
  );

  assign acc = '{hit: hit, wr: we_i, rd: re_i};

  io_strobe_gen #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SEL_LSB(SEL_LSB)) u_stb (
    .addr_i  (addr_i),
    .acc_i   (acc),
    .wr_stb_o(wr_stb_o),
    .rd_stb_o(rd_stb_o)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    localparam int KW = (i == 0) ? LED_W : DATA_W;
    io_reg_slot #(.DATA_W(DATA_W), .KEEP_W(KW)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(wr_stb_o[i]),
      .wdata_i(wdata_i),
      .q_o    (regs_o[i*DATA_W +: DATA_W])
    );
  end

  io_read_or #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
    .sel_i    (rd_stb_o),
    .regs_i   (regs_o),
    .rd_data_o(rd_data_o)
  );

  assign led_o = regs_o[LED_W-1:0];
endmodule

// File: rtl/io_onehot_dec_chk.sv
module io_onehot_dec_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int SEL_LSB  = 2,
  parameter int LED_W    = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [DATA_W-1:0]          wdata_i,
  input logic                       we_i,
  input logic                       re_i,
  input logic                       io_en_i,
  input logic [NUM_REGS-1:0]        wr_stb_o,
  input logic [NUM_REGS-1:0]        rd_stb_o,
  input logic [DATA_W-1:0]          rd_data_o,
  input logic [LED_W-1:0]           led_o,
  input logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int HI_LSB = SEL_LSB + NUM_REGS;
  logic in_win;
  assign in_win = io_en_i && (&addr_i[ADDR_W-1:HI_LSB]);

  // R2
  wr_needs_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_stb_o) |-> we_i);
  // R5
  rd_needs_re_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_stb_o) |-> re_i);
  // R6
  miss_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> (wr_stb_o == '0 && rd_stb_o == '0));
  // R4
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_o == '0) |-> (rd_data_o == '0));
  // R8
  led_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o == regs_o[LED_W-1:0] && regs_o[DATA_W-1:LED_W] == '0);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int KW = (i == 0) ? LED_W : DATA_W;
    localparam logic [DATA_W-1:0] KEEP = {DATA_W{1'b1}} >> (DATA_W - KW);
    // R3
    reg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_stb_o[i] |=> regs_o[i*DATA_W +: DATA_W] == ($past(wdata_i) & KEEP));
    // R6
    reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_stb_o[i] |=> $stable(regs_o[i*DATA_W +: DATA_W]));
  end
endmodule

bind io_onehot_dec io_onehot_dec_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
  .SEL_LSB(SEL_LSB), .LED_W(LED_W)
) chk_i (.*);

// File: tb/io_onehot_dec_tb.sv
module io_onehot_dec_tb_top;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int DW    = 32;
  localparam logic [31:0] BASE = 32'hFFFF_FC00;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic we_i = 1'b0, re_i = 1'b0, io_en_i = 1'b0;
  logic [N-1:0] wr_stb_o, rd_stb_o;
  logic [DW-1:0] rd_data_o;
  logic [7:0] led_o;
  logic [N*DW-1:0] regs_o;

  int total = 0, bad = 0;
  logic [DW-1:0] model [N];

  always #(CLK_P/2) clk_i = ~clk_i;

  io_onehot_dec dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_or(input int m);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < N; i++) if (m[i]) r |= model[i];
    return r;
  endfunction

  task automatic chk_bank(input string req);
    for (int i = 0; i < N; i++)
      chk(regs_o[i*DW +: DW] == model[i], req, regs_o[i*DW +: DW], model[i]);
    chk(led_o == model[0][7:0], req, 32'(led_o), model[0]);
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R7 reset state
    chk(regs_o == '0, "R7", regs_o[31:0], 0);
    chk(wr_stb_o == '0 && rd_stb_o == '0, "R7", 32'({wr_stb_o, rd_stb_o}), 0);
    rst_ni = 1'b1;

    // R2 R3 R4 R5 R8 R9: every one-hot field value
    for (int m = 0; m < 256; m++) begin
      @(negedge clk_i);
      io_en_i = 1'b1;
      addr_i  = BASE | (32'(m) << 2) | 32'(m & 3);
      wdata_i = {8'(m), ~8'(m), 8'(m) ^ 8'hA5, 8'(m * 7 + 3)};
      we_i = 1'b1; re_i = 1'b0;
      #1;
      chk(wr_stb_o == 8'(m), "R2", 32'(wr_stb_o), 32'(m));
      chk(rd_stb_o == '0, "R5", 32'(rd_stb_o), 0);
      @(posedge clk_i);
      for (int i = 0; i < N; i++)
        if (m[i]) model[i] = (i == 0) ? {24'h0, wdata_i[7:0]} : wdata_i;
      @(negedge clk_i);
      we_i = 1'b0; re_i = 1'b1;
      addr_i = BASE | (32'(m) << 2) | 32'(3 - (m & 3));
      #1;
      chk(rd_stb_o == 8'(m), "R5", 32'(rd_stb_o), 32'(m));
      chk(wr_stb_o == '0, "R2", 32'(wr_stb_o), 0);
      chk(rd_data_o == exp_or(m), "R4", rd_data_o, exp_or(m));
      chk_bank("R3");
    end

    // R1 R10 top-most register
    @(negedge clk_i);
    addr_i = 32'hFFFF_FE00; re_i = 1'b1; we_i = 1'b1; wdata_i = 32'h1357_9BDF;
    #1;
    chk(wr_stb_o == 8'h80 && rd_stb_o == 8'h80, "R10", 32'(wr_stb_o), 32'h80);
    @(posedge clk_i);
    model[7] = 32'h1357_9BDF;
    @(negedge clk_i);
    we_i = 1'b0; #1;
    chk(rd_data_o == 32'h1357_9BDF, "R1", rd_data_o, 32'h1357_9BDF);

    // R6 misses: each upper bit cleared, then select dropped
    for (int b = 10; b <= 32; b++) begin
      @(negedge clk_i);
      io_en_i = (b != 32);
      addr_i  = 32'hFFFF_FFFF;
      if (b < 32) addr_i[b] = 1'b0;
      wdata_i = 32'hDEAD_0000 | 32'(b);
      we_i = 1'b1; re_i = 1'b1;
      #1;
      chk(wr_stb_o == '0 && rd_stb_o == '0, "R6", 32'({wr_stb_o, rd_stb_o}), 0);
      chk(rd_data_o == '0, "R6", rd_data_o, 0);
      @(posedge clk_i);
      @(negedge clk_i);
      we_i = 1'b0; re_i = 1'b0;
      #1;
      chk_bank("R6");
    end

    // R1 full window with select restored
    @(negedge clk_i);
    io_en_i = 1'b1; addr_i = 32'hFFFF_FFFF; re_i = 1'b1;
    #1;
    chk(rd_stb_o == 8'hFF, "R1", 32'(rd_stb_o), 32'hFF);
    chk(rd_data_o == exp_or(255), "R4", rd_data_o, exp_or(255));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule